// File: doc/BRIEF.md
# Delayed Supervisor Reset Generator

The block drives the active-low reset line of a microcontroller. Two asynchronous flags come in. One says the regulated supply rail is above its reset threshold; an analog comparator outside the block decides that. The other says the die is in thermal shutdown. The output stays low out of power-on. It goes high only once the rail has been good for a long, unbroken stretch, nominally 100 ms and within a 70 to 140 ms window.

Once released, the output ignores short rail dips. It returns low only if the rail stays below threshold for a short filter time, nominally 7.5 us and within 3 to 15 us. Regulator current limiting that pulls the rail down is seen the same way. Thermal shutdown switches the regulator off, so it forces reset at once, without the filter. When the die cools, the full release delay runs again.

Both delays are derived from the clock rate in kHz, the release time in microseconds and the filter time in nanoseconds. Both flags pass through a synchronizer before any decision is taken.

Top module: `supervisor_reset_gen`

## Requirements
- R1: While the power-on reset input is low, and afterwards until a release, the reset output is 0.
- R2: With the rail good and no thermal shutdown, the output goes to 1 exactly SYNC_STAGES+REL_CNT+1 clock cycles after the rail flag rises. REL_CNT is CLK_KHZ*RELEASE_US/1000.
- R3: The output never goes to 1 while the synchronized rail flag is low or the synchronized thermal flag is high.
- R4: Any rail-low sample during the release delay clears the release count. The delay then restarts in full from the next good sample.
- R5: After release, a rail-low level that lasts AST_CNT consecutive cycles drives the output to 0 exactly SYNC_STAGES+AST_CNT+1 cycles after the flag falls. AST_CNT is CLK_KHZ*FILTER_NS/1000000.
- R6: After release, a rail-low level lasting fewer than AST_CNT cycles leaves the output at 1.
- R7: A thermal shutdown drives the output to 0 exactly SYNC_STAGES+1 cycles after its flag rises, with the rail flag still high. The output stays 0 for as long as the flag remains set.
- R8: Once the thermal flag clears with the rail good, the output returns to 1 only after the full release delay of R2.
- R9: The release count saturates at REL_CNT and never wraps. The output stays at 1 through any length of good rail.
- R10: Both input flags pass through SYNC_STAGES flip-flops before use, and every latency above includes these stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_KHZ |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rail_ok_i | input | 1 | Asynchronous flag: rail above reset threshold |
| over_temp_i | input | 1 | Asynchronous flag: thermal shutdown active |
| mcu_rst_n_o | output | 1 | Reset to the microcontroller, active low |

## Verification
The hardest case to reach from the ports is a restart of the release delay part-way through the count. A single low sample must land after the count has built up but before it completes, and the bench must then show that the count starts over. The bench keeps the rail good for most of the delay, drops it for two cycles, and then measures the rise latency from the moment the rail is good again. It also checks that the output never rose in between. The filter boundary is approached the same way. A dip one cycle shorter than the filter must leave the output high, and a dip of exactly the filter length must produce the fall at the computed cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } sup_state_e;

    typedef struct packed {
        sup_state_e state;
        logic       rst_n;
    } sup_regs_t;

endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
    parameter int unsigned LIMIT = 10,
    parameter int unsigned W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         full
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = '0;
        else if (inc && cnt_q < LIM) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign full = (cnt_q == LIM);
endmodule

// File: rtl/supervisor_reset_gen.sv
module supervisor_reset_gen
    import sup_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 200000,
    parameter int unsigned RELEASE_US  = 100000,
    parameter int unsigned FILTER_NS   = 7500,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rail_ok_i,
    input  logic over_temp_i,
    output logic mcu_rst_n_o
);
    localparam int unsigned REL_CNT =
        int'((64'(CLK_KHZ) * 64'(RELEASE_US)) / 64'd1000);
    localparam int unsigned AST_CNT =
        int'((64'(CLK_KHZ) * 64'(FILTER_NS)) / 64'd1000000);
    localparam int unsigned REL_W = $clog2(REL_CNT + 1);
    localparam int unsigned AST_W = $clog2(AST_CNT + 1);

    logic [1:0]       sync_flags;
    logic             s_rail;
    logic             s_therm;
    logic             good;
    logic [REL_W-1:0] rel_cnt;
    logic             rel_full;
    logic [AST_W-1:0] low_cnt;
    logic             low_full;
    logic             low_clr;
    sup_regs_t        regs_d;
    sup_regs_t        regs_q;

    lvl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i ({over_temp_i, rail_ok_i}),
        .sync_o  (sync_flags)
    );

    assign s_rail  = sync_flags[0];
    assign s_therm = sync_flags[1];
    assign good    = s_rail & ~s_therm;

    // release timer: consecutive good samples, saturating
    sat_cnt #(.LIMIT(REL_CNT), .W(REL_W)) u_rel (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (~good),
        .inc   (good),
        .cnt   (rel_cnt),
        .full  (rel_full)
    );

    // dip filter: consecutive low samples while released
    assign low_clr = s_rail | (regs_q.state == ST_HOLD);

    sat_cnt #(.LIMIT(AST_CNT), .W(AST_W)) u_low (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (low_clr),
        .inc   (~s_rail),
        .cnt   (low_cnt),
        .full  (low_full)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_HOLD: if (rel_full && good)        regs_d.state = ST_RUN;
            ST_RUN:  if (s_therm || low_full)     regs_d.state = ST_HOLD;
            default:                              regs_d.state = ST_HOLD;
        endcase
        regs_d.rst_n = (regs_d.state == ST_RUN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) regs_q <= '{state: ST_HOLD, rst_n: 1'b0};
        else        regs_q <= regs_d;
    end

    assign mcu_rst_n_o = regs_q.rst_n;
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
    parameter int unsigned REL_CNT = 10,
    parameter int unsigned AST_CNT = 4,
    parameter int unsigned REL_W   = 4,
    parameter int unsigned AST_W   = 3
) (
    input logic             clk,
    input logic             por_n,
    input logic             s_rail,
    input logic             s_therm,
    input logic [REL_W-1:0] rel_cnt,
    input logic [AST_W-1:0] low_cnt,
    input logic             mcu_rst_n_o
);
    localparam logic [REL_W-1:0] REL_LIM = REL_W'(REL_CNT);
    localparam logic [AST_W-1:0] AST_LIM = AST_W'(AST_CNT);

    always_comb begin
        if (!por_n) a_por_low_r1: assert (!mcu_rst_n_o);
    end

    p_release_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mcu_rst_n_o) |-> ($past(rel_cnt) == REL_LIM));

    p_good_only_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mcu_rst_n_o) |-> ($past(s_rail) && !$past(s_therm)));

    p_restart_r4: assert property (@(posedge clk) disable iff (!por_n)
        !s_rail |=> (rel_cnt == '0));

    p_filter_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(mcu_rst_n_o) |-> ($past(low_cnt) == AST_LIM || $past(s_therm)));

    p_dip_ignored_r6: assert property (@(posedge clk) disable iff (!por_n)
        (mcu_rst_n_o && low_cnt != AST_LIM && !s_therm) |=> mcu_rst_n_o);

    p_therm_r7: assert property (@(posedge clk) disable iff (!por_n)
        s_therm |=> !mcu_rst_n_o);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!por_n)
        rel_cnt <= REL_LIM);
endmodule

bind supervisor_reset_gen sup_reset_chk #(
    .REL_CNT (REL_CNT),
    .AST_CNT (AST_CNT),
    .REL_W   (REL_W),
    .AST_W   (AST_W)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .s_rail      (s_rail),
    .s_therm     (s_therm),
    .rel_cnt     (rel_cnt),
    .low_cnt     (low_cnt),
    .mcu_rst_n_o (mcu_rst_n_o)
);

// File: tb/sim_supervisor_reset_gen.sv
`timescale 1ns/1ps
module sim_supervisor_reset_gen;
    // 1000 kHz nominal for count derivation: REL = 24, AST = 6
    localparam int unsigned CLK_KHZ = 1000;
    localparam int unsigned REL_US  = 24;
    localparam int unsigned FIL_NS  = 6000;
    localparam int unsigned SYNC    = 2;
    localparam int unsigned REL     = CLK_KHZ * REL_US / 1000;
    localparam int unsigned AST     = CLK_KHZ * FIL_NS / 1000000;
    localparam int unsigned L_REL   = SYNC + REL + 1;
    localparam int unsigned L_AST   = SYNC + AST + 1;
    localparam int unsigned L_TH    = SYNC + 1;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rail = 1'b0;
    logic therm = 1'b0;
    logic rst_out;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    supervisor_reset_gen #(
        .CLK_KHZ(CLK_KHZ), .RELEASE_US(REL_US),
        .FILTER_NS(FIL_NS), .SYNC_STAGES(SYNC)
    ) u0 (
        .clk(clk), .por_n(por_n), .rail_ok_i(rail),
        .over_temp_i(therm), .mcu_rst_n_o(rst_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycles until output reaches target; returns max+1 if never
    task automatic measure(input logic target, input int max, output int cyc);
        cyc = max + 1;
        for (int k = 1; k <= max; k++) begin
            @(negedge clk);
            if (rst_out == target) begin
                cyc = k;
                break;
            end
        end
    endtask

    // output must keep value for n cycles; returns 1 if it did
    task automatic hold_for(input logic val, input int n, output int ok);
        ok = 1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_out != val) ok = 0;
        end
    endtask

    task automatic t_reset_state();
        int ok;
        check("R1 low during por", int'(rst_out), 0);
        @(negedge clk);
        por_n = 1'b1;
        hold_for(1'b0, 40, ok);
        check("R1 low with rail bad after por", ok, 1);
    endtask

    task automatic t_first_release();
        int cyc;
        rail = 1'b1;
        measure(1'b1, 60, cyc);
        check("R2 R10 release latency", cyc, L_REL);
    endtask

    task automatic t_saturate();
        int ok;
        hold_for(1'b1, 3 * REL + 20, ok);
        check("R9 stays released through long good rail", ok, 1);
    endtask

    task automatic t_short_dip();
        int ok;
        rail = 1'b0;
        repeat (AST - 1) @(negedge clk);
        rail = 1'b1;
        hold_for(1'b1, 20, ok);
        check("R6 dip of AST-1 cycles ignored", ok, 1);
    endtask

    task automatic t_long_dip();
        int cyc;
        rail = 1'b0;
        repeat (AST) @(negedge clk);
        rail = 1'b1;
        measure(1'b0, 20, cyc);
        check("R5 dip of exactly AST cycles asserts", cyc, L_AST - AST);
        // rail recovered, so a fresh release follows
        measure(1'b1, 60, cyc);
        check("R2 release after recovered dip", cyc, L_REL - (L_AST - AST));
    endtask

    task automatic t_fall_latency();
        int cyc;
        rail = 1'b0;
        measure(1'b0, 30, cyc);
        check("R5 assert latency", cyc, L_AST);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_restart();
        int ok;
        int cyc;
        rail = 1'b1;
        hold_for(1'b0, REL - 4, ok);
        rail = 1'b0;
        repeat (2) @(negedge clk);
        rail = 1'b1;
        check("R4 no release before restart", ok && rst_out == 1'b0, 1);
        measure(1'b1, 60, cyc);
        check("R4 full delay after restart", cyc, L_REL);
    endtask

    task automatic t_thermal();
        int ok;
        int cyc;
        therm = 1'b1;
        measure(1'b0, 20, cyc);
        check("R7 thermal latency", cyc, L_TH);
        hold_for(1'b0, 50, ok);
        check("R7 R3 held while thermal set", ok, 1);
        therm = 1'b0;
        measure(1'b1, 60, cyc);
        check("R8 full delay after thermal", cyc, L_REL);
    endtask

    task automatic t_thermal_in_hold();
        int ok;
        int cyc;
        rail = 1'b0;
        measure(1'b0, 30, cyc);
        check("R5 assert before thermal test", cyc, L_AST);
        rail = 1'b1;
        repeat (REL - 6) @(negedge clk);
        therm = 1'b1;
        repeat (3) @(negedge clk);
        therm = 1'b0;
        check("R3 no release during thermal", int'(rst_out), 0);
        measure(1'b1, 60, cyc);
        check("R8 thermal during delay restarts it", cyc, L_REL);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_first_release();
        t_saturate();
        t_short_dip();
        t_long_dip();
        t_fall_latency();
        t_restart();
        t_thermal();
        t_thermal_in_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule